// File: doc/BRIEF.md
# Block Move Copy Engine

The engine copies a run of bytes from one place in memory to another on behalf of a processor. It does the same work as a repeated load-and-step string move. A single start pulse loads four things: a source pointer, a destination pointer, a byte count and a direction flag. The engine then walks both pointers together. For each byte it reads one location and writes the byte it read to the other location, using a simple synchronous memory port that has a ready handshake.

The copy runs strictly one byte at a time, in the order requested, with no buffering. Overlapping regions therefore give exactly the result of a sequential processor loop. For example, a forward copy to the next higher address fills the whole region with the first byte. A count of zero asks for the whole address space. Both pointers wrap around at the ends of the space in either direction. When the copy ends the engine pulses done and keeps the last byte it moved on an output.

Top module: `block_copy_engine`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, busy, done, the read strobe and the write strobe are all 0 and the last-byte output is 0.
- R2: A start pulse seen while the engine is idle captures the source, destination, count and direction inputs, and busy rises in the next cycle. A start pulse seen while busy is high is ignored: the running copy goes on unchanged.
- R3: Each byte is moved as a read of the source pointer followed by a write of that same byte to the destination pointer. The read strobe and the write strobe are never high in the same cycle.
- R4: With the direction input at 0, both pointers go up by one after each byte. With it at 1, both go down by one.
- R5: Both pointers wrap modulo 2^ADDR_W: stepping up from the highest address gives 0, and stepping down from 0 gives the highest address.
- R6: A loaded count of 0 moves 2^CNT_W bytes.
- R7: A copy with count N (N ≥ 1) moves exactly N bytes, in order. The final memory contents equal those of a byte-by-byte sequential copy, including when the source and destination regions overlap.
- R8: A read or write request stays asserted until ready is seen high. While it waits, its address (and for a write its data) stays unchanged. Ready is sampled in every cycle of a request, including the first.
- R9: done is high for exactly one cycle at the end of a copy. busy stays high from the cycle after start through that done cycle, and it is low in the cycle after done.
- R10: When done is high, the last-byte output holds the value of the final byte moved. It keeps that value while the engine is idle.
- R11: When ready is always high, a copy of N bytes keeps busy high for exactly 2N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken only while idle |
| src_i | input | ADDR_W | First source address |
| dst_i | input | ADDR_W | First destination address |
| len_i | input | CNT_W | Byte count, 0 meaning 2^CNT_W |
| down_i | input | 1 | 0 = pointers ascend, 1 = pointers descend |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle end-of-copy pulse |
| last_byte_o | output | DATA_W | Final byte moved |
| mem_rd_o | output | 1 | Read request |
| mem_wr_o | output | 1 | Write request |
| mem_addr_o | output | ADDR_W | Request address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid when ready is high during a read |
| mem_ready_i | input | 1 | Request completes in this cycle |

## Verification
The bench builds the engine with ADDR_W = 10, CNT_W = 10 and DATA_W = 8. With these values the bench memory can cover the whole 1 KB address space. A zero count then moves 1024 bytes in about two thousand cycles, so a full-space copy in each direction is cheap to run. Pointer wrap at both ends and overlapping copies across the full space can be compared against a sequential model of the whole memory. Random ready stalls show that requests are held steady, and runs with no stalls pin the cycle count per byte.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    // Control states of the copy sequencer
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_REQ  = 3'd1,
        ST_RD_WAIT = 3'd2,
        ST_WR_REQ  = 3'd3,
        ST_WR_WAIT = 3'd4,
        ST_DONE    = 3'd5
    } bmc_state_e;

    // Pointer channels: index 0 walks the source, index 1 the destination
    localparam int BMC_NUM_PTR = 2;
    localparam int BMC_SRC_IDX = 0;
    localparam int BMC_DST_IDX = 1;

endpackage

// File: rtl/bmc_ptr_step.sv
module bmc_ptr_step #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] init_i,
    input  logic          down_i,
    input  logic          step_i,
    output logic [AW-1:0] ptr_o
);
    localparam logic [AW-1:0] UNIT = AW'(1);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          down;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.ptr  = init_i;
            st_d.down = down_i;
        end else if (step_i) begin
            // modulo 2^AW in both directions (R5)
            if (st_q.down) begin
                st_d.ptr = st_q.ptr - UNIT;
            end else begin
                st_d.ptr = st_q.ptr + UNIT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;

    // R4: ascending step advances by exactly one
    p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !load_i && !st_q.down |=> ptr_o == $past(ptr_o) + UNIT);

    // R5: descending step wraps below zero to the top
    p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !load_i && st_q.down |=> ptr_o == $past(ptr_o) - UNIT);

    // R7: pointer does not drift between steps
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i && !load_i |=> $stable(ptr_o));

endmodule

// File: rtl/bmc_len_count.sv
module bmc_len_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] len_i,
    input  logic          dec_i,
    output logic          final_o
);
    localparam logic [CW-1:0] UNIT = CW'(1);

    typedef struct packed {
        logic [CW-1:0] left;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.left = len_i;
        end else if (dec_i) begin
            // a loaded zero wraps to all ones, giving 2^CW bytes (R6)
            st_d.left = st_q.left - UNIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // current byte is the last one when exactly one remains
    assign final_o = (st_q.left == UNIT);

    // R6: each completed byte removes one from the remaining count
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i && !load_i |=> st_q.left == $past(st_q.left) - UNIT);

    // R7: count only moves on a load or a completed byte
    p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_i && !load_i |=> $stable(st_q.left));

endmodule

// File: rtl/bmc_ctrl.sv
module bmc_ctrl
    import bmc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          ready_i,
    input  logic [DW-1:0] rdata_i,
    input  logic          final_i,
    output logic          load_o,
    output logic          step_o,
    output logic          rd_o,
    output logic          wr_o,
    output logic          use_dst_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] byte_o
);
    typedef struct packed {
        bmc_state_e    state;
        logic [DW-1:0] data;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        load_o    = 1'b0;
        step_o    = 1'b0;
        rd_o      = 1'b0;
        wr_o      = 1'b0;
        use_dst_o = 1'b0;
        done_o    = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    load_o     = 1'b1;
                    st_d.state = ST_RD_REQ;
                end
            end
            ST_RD_REQ, ST_RD_WAIT: begin
                rd_o = 1'b1;
                if (ready_i) begin
                    st_d.data  = rdata_i;
                    st_d.state = ST_WR_REQ;
                end else begin
                    st_d.state = ST_RD_WAIT;
                end
            end
            ST_WR_REQ, ST_WR_WAIT: begin
                wr_o      = 1'b1;
                use_dst_o = 1'b1;
                if (ready_i) begin
                    step_o     = 1'b1;
                    st_d.state = final_i ? ST_DONE : ST_RD_REQ;
                end else begin
                    st_d.state = ST_WR_WAIT;
                end
            end
            ST_DONE: begin
                done_o     = 1'b1;
                st_d.state = ST_IDLE;
            end
            default: begin
                st_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = (st_q.state != ST_IDLE);
    assign byte_o = st_q.data;

    // R2: no reload of the pointers or count while a copy runs
    p_no_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !load_o);

    // R3: a write is always preceded by its read
    p_write_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_o) |-> $past(rd_o));

    // R10: captured byte is frozen outside the read phase
    p_byte_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_o |=> $stable(byte_o));

endmodule

// File: rtl/block_copy_engine.sv
module block_copy_engine
    import bmc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic              down_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] last_byte_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i
);
    logic              load_w;
    logic              step_w;
    logic              final_w;
    logic              use_dst_w;
    logic [DATA_W-1:0] byte_w;
    logic [ADDR_W-1:0] seed_w [BMC_NUM_PTR];
    logic [ADDR_W-1:0] ptr_w  [BMC_NUM_PTR];

    assign seed_w[BMC_SRC_IDX] = src_i;
    assign seed_w[BMC_DST_IDX] = dst_i;

    // Source and destination pointers step together after each write
    for (genvar g = 0; g < BMC_NUM_PTR; g++) begin : g_ptr
        bmc_ptr_step #(
            .AW (ADDR_W)
        ) i_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load_w),
            .init_i (seed_w[g]),
            .down_i (down_i),
            .step_i (step_w),
            .ptr_o  (ptr_w[g])
        );
    end

    bmc_len_count #(
        .CW (CNT_W)
    ) i_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .len_i   (len_i),
        .dec_i   (step_w),
        .final_o (final_w)
    );

    bmc_ctrl #(
        .DW (DATA_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .ready_i   (mem_ready_i),
        .rdata_i   (mem_rdata_i),
        .final_i   (final_w),
        .load_o    (load_w),
        .step_o    (step_w),
        .rd_o      (mem_rd_o),
        .wr_o      (mem_wr_o),
        .use_dst_o (use_dst_w),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .byte_o    (byte_w)
    );

    assign mem_addr_o  = use_dst_w ? ptr_w[BMC_DST_IDX] : ptr_w[BMC_SRC_IDX];
    assign mem_wdata_o = byte_w;
    assign last_byte_o = byte_w;

    // R3: never read and write in the same cycle
    p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o}));

    // R8: a stalled read keeps its request and address
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o && !mem_ready_i |=> mem_rd_o && $stable(mem_addr_o));

    // R8: a stalled write keeps its request, address and data
    p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o && !mem_ready_i |=>
            mem_wr_o && $stable(mem_addr_o) && $stable(mem_wdata_o));

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: busy only drops right after done
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> busy_o);

    // R9: busy is low in the cycle after done
    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R10: last byte output is held while idle
    p_last_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(last_byte_o));

endmodule

// File: tb/test_block_copy_engine.sv
`timescale 1ns/1ps
module test_block_copy_engine;
    localparam int AW  = 10;
    localparam int CW  = 10;
    localparam int DW  = 8;
    localparam int MSZ = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] len;
        logic          down;
        logic          stall;
    } vec_t;

    // R4 basic up/down, R7 overlaps, R5 wraps, R6 zero count, R8 stalls
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{10'h010, 10'h200, 10'd16, 1'b0, 1'b0},
        '{10'h120, 10'h300, 10'd20, 1'b1, 1'b1},
        '{10'h050, 10'h051, 10'd12, 1'b0, 1'b0},
        '{10'h081, 10'h080, 10'd12, 1'b1, 1'b1},
        '{10'h3F8, 10'h100, 10'd16, 1'b0, 1'b0},
        '{10'h005, 10'h380, 10'd10, 1'b1, 1'b0},
        '{10'h200, 10'h3FA, 10'd12, 1'b0, 1'b1},
        '{10'h002, 10'h003, 10'd1,  1'b0, 1'b0},
        '{10'h000, 10'h001, 10'd0,  1'b0, 1'b0},
        '{10'h140, 10'h2A0, 10'd0,  1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src = '0;
    logic [AW-1:0] dst = '0;
    logic [CW-1:0] len = '0;
    logic          down = 1'b0;
    logic          busy, done, rd, wr, ready;
    logic [DW-1:0] last_byte, wdata, rdata;
    logic [AW-1:0] maddr;

    logic [DW-1:0] bmem [MSZ];
    logic [DW-1:0] rmem [MSZ];
    logic          fill_en = 1'b0;
    int            fill_seed = 0;
    logic          stall_en = 1'b0;
    logic [7:0]    lfsr = 8'hA5;
    logic          stall_q = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    block_copy_engine #(
        .ADDR_W (AW),
        .CNT_W  (CW),
        .DATA_W (DW)
    ) i_block_copy_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .src_i       (src),
        .dst_i       (dst),
        .len_i       (len),
        .down_i      (down),
        .busy_o      (busy),
        .done_o      (done),
        .last_byte_o (last_byte),
        .mem_rd_o    (rd),
        .mem_wr_o    (wr),
        .mem_addr_o  (maddr),
        .mem_wdata_o (wdata),
        .mem_rdata_i (rdata),
        .mem_ready_i (ready)
    );

    function automatic logic [DW-1:0] pat(int i, int seed);
        return DW'(i * 37 + seed * 11 + (i >> 4));
    endfunction

    // memory model
    assign ready = (rd || wr) && !stall_q;
    assign rdata = bmem[maddr];

    always @(posedge clk) begin
        if (fill_en) begin
            for (int i = 0; i < MSZ; i++) bmem[i] <= pat(i, fill_seed);
        end else if (wr && ready) begin
            bmem[maddr] <= wdata;
        end
    end

    always @(negedge clk) begin
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        stall_q <= stall_en && lfsr[0];
    end

    task automatic chk(input string tag, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic run_copy(input logic [AW-1:0] s, input logic [AW-1:0] d,
                            input logic [CW-1:0] c, input logic dn, input logic st,
                            input int inj_at, input int seed, input string tag);
        int n, busy_n, done_n, bad_proto, cyc, rd_seen, mism, first_bad;
        logic [AW-1:0] rs, rdst, rd_addr0, rd_addr1, wr_addr0;
        logic [DW-1:0] exp_last, last_at_done;
        logic pend_rd, pend_wr, fin, prev_rd;
        logic [AW-1:0] pend_addr;
        logic [DW-1:0] pend_data;
        n = (c == '0) ? (1 << CW) : int'(c);
        fill_seed = seed;
        fill_en = 1'b1;
        tick();
        fill_en = 1'b0;
        for (int i = 0; i < MSZ; i++) rmem[i] = pat(i, seed);
        rs = s;
        rdst = d;
        exp_last = '0;
        for (int k = 0; k < n; k++) begin
            exp_last = rmem[rs];
            rmem[rdst] = exp_last;
            rs   = dn ? rs - AW'(1) : rs + AW'(1);
            rdst = dn ? rdst - AW'(1) : rdst + AW'(1);
        end
        stall_en = st;
        src = s; dst = d; len = c; down = dn; start = 1'b1;
        tick();
        start = 1'b0;
        busy_n = 0; done_n = 0; bad_proto = 0; cyc = 0; rd_seen = 0;
        rd_addr0 = '0; rd_addr1 = '0; wr_addr0 = '0; last_at_done = '0;
        pend_rd = 1'b0; pend_wr = 1'b0; pend_addr = '0; pend_data = '0;
        fin = 1'b0; prev_rd = 1'b0;
        while (!fin && cyc < 20000) begin
            if (busy) busy_n++;
            if (rd && wr) bad_proto++;
            if (pend_rd && !(rd && maddr == pend_addr)) bad_proto++;
            if (pend_wr && !(wr && maddr == pend_addr && wdata == pend_data)) bad_proto++;
            if (rd && !prev_rd) begin
                if (rd_seen == 0) rd_addr0 = maddr;
                if (rd_seen == 1) rd_addr1 = maddr;
                rd_seen++;
            end
            if (wr && rd_seen == 1) wr_addr0 = maddr;
            pend_rd = rd && !ready;
            pend_wr = wr && !ready;
            pend_addr = maddr;
            pend_data = wdata;
            prev_rd = rd && !ready;
            if (done) begin
                done_n++;
                fin = 1'b1;
                last_at_done = last_byte;
            end
            start = (cyc == inj_at);
            if (start) begin
                src = ~s; dst = ~d; len = CW'(3); down = ~dn;
            end
            cyc++;
            tick();
        end
        start = 1'b0;
        chk({tag, " R9 copy finished"}, fin, int'(fin), 1);
        chk("R9 done low after pulse", !done, int'(done), 0);
        chk("R9 busy low after done", !busy, int'(busy), 0);
        done_n += int'(done);
        chk("R9 single done pulse", done_n == 1, done_n, 1);
        chk("R3 R8 request protocol", bad_proto == 0, bad_proto, 0);
        chk("R3 first read at source", rd_addr0 == s, int'(rd_addr0), int'(s));
        chk("R3 first write at destination", wr_addr0 == d, int'(wr_addr0), int'(d));
        if (n > 1) begin
            rs = dn ? s - AW'(1) : s + AW'(1);
            chk({tag, " R4 second read address"}, rd_addr1 == rs, int'(rd_addr1), int'(rs));
        end
        chk("R10 last byte at done", last_at_done == exp_last, int'(last_at_done), int'(exp_last));
        if (!st) begin
            chk("R11 busy cycles", busy_n == 2 * n + 1, busy_n, 2 * n + 1);
        end
        mism = 0;
        first_bad = -1;
        for (int i = 0; i < MSZ; i++) begin
            if (bmem[i] !== rmem[i]) begin
                if (first_bad < 0) first_bad = i;
                mism++;
            end
        end
        chk({tag, " R7 memory image"}, mism == 0, mism, 0);
        if (mism != 0) $display("  first mismatch at %0d", first_bad);
        stall_en = 1'b1;
        tick();
        tick();
        chk("R10 last byte held while idle", last_byte == exp_last, int'(last_byte), int'(exp_last));
        stall_en = 1'b0;
    endtask

    function automatic string vec_tag(int k);
        case (k)
            0, 1:    return "R4";
            2, 3:    return "R7-overlap";
            4, 5, 6: return "R5";
            7:       return "R7-single";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: state under reset and right after release
        tick();
        tick();
        chk("R1 busy in reset", busy == 1'b0, int'(busy), 0);
        chk("R1 strobes in reset", !rd && !wr && !done, int'({rd, wr, done}), 0);
        chk("R1 last byte in reset", last_byte == '0, int'(last_byte), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 idle after release", !busy && !rd && !wr && !done,
            int'({busy, rd, wr, done}), 0);

        // R2: busy rises one cycle after start
        src = 10'h020; dst = 10'h040; len = 10'd4; down = 1'b0; start = 1'b1;
        chk("R2 not busy in start cycle", !busy, int'(busy), 0);
        tick();
        start = 1'b0;
        chk("R2 busy after start", busy, int'(busy), 1);
        while (busy) tick();

        for (int k = 0; k < NV; k++) begin
            run_copy(VECS[k].src, VECS[k].dst, VECS[k].len, VECS[k].down,
                     VECS[k].stall, -1, k + 3, vec_tag(k));
        end

        // R2: start pulses in the middle of a copy are ignored
        run_copy(10'h060, 10'h0A0, 10'd24, 1'b0, 1'b0, 7, 21, "R2");
        run_copy(10'h1F0, 10'h170, 10'd18, 1'b1, 1'b1, 5, 22, "R2");

        // R1: reset in the middle of a copy returns to idle
        src = 10'h010; dst = 10'h300; len = 10'd40; down = 1'b0; start = 1'b1;
        tick();
        start = 1'b0;
        for (int i = 0; i < 9; i++) tick();
        rst_n = 1'b0;
        tick();
        chk("R1 mid-copy reset clears busy", !busy && !rd && !wr,
            int'({busy, rd, wr}), 0);
        chk("R1 mid-copy reset clears last byte", last_byte == '0, int'(last_byte), 0);
        rst_n = 1'b1;
        tick();
        run_copy(10'h3FE, 10'h3FF, 10'd5, 1'b0, 1'b0, -1, 30, "R5");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule